// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer Controller

This block sits between an 8-bit processor that shares its pins over time and a conventional memory and I/O system that needs separate, stable buses. The processor puts the low address byte on the shared address/data lines and the top four address bits on lines that later carry status. It marks that address phase with an address-latch strobe. The block captures all twenty address bits in the cycles where that strobe is high and holds them for the rest of the bus cycle. The whole capture is loaded in one step, including the eight address-only lines, so the full address changes as a single unit.

From the active-low read and write requests and the memory/I-O select line, the block decodes four active-high command strobes. These are memory read, memory write, I/O read and I/O write. A two-way data transceiver is steered by the direction line and the active-low data-enable line. It moves bytes from the memory side toward the processor or from the processor toward memory. Each side has its own output-enable signal, so no tri-state logic exists inside the core. Every output is registered: a change on the inputs appears after the next rising clock edge. The asynchronous active-low reset is released synchronously through a two-stage synchronizer.

Top module: `bus_demux_ctrl`

## Requirements
- R1: While reset is asserted, and until the first input activity after it, `addr` is 0 and all four command strobes, both output enables and both data outputs are 0.
- R2: After a rising edge at which `ale` is 1, `addr` equals {`as_hi`, `a_mid`, `ad_in`}. Bits 19..16 come from `as_hi`, bits 15..8 from `a_mid` and bits 7..0 from `ad_in`.
- R3: After a rising edge at which `ale` is 0, `addr` keeps its previous value, whatever the shared lines, the status lines and the address-only lines carry.
- R4: After each rising edge, `memr` equals (not `rd_n`) and (not `io_m`) and (not `ale`), and `memw` equals (not `wr_n`) and (not `io_m`) and (not `ale`), using the values sampled at that edge. `io_m` = 0 selects memory.
- R5: After each rising edge, `ior` equals (not `rd_n`) and `io_m` and (not `ale`), and `iow` equals (not `wr_n`) and `io_m` and (not `ale`). `io_m` = 1 selects I/O.
- R6: After a rising edge at which `ale` is 1, all four command strobes are 0, even if `rd_n` or `wr_n` is low.
- R7: After a rising edge with `den_n` = 0, `dt_r` = 0 and `ale` = 0, `ad_oe` is 1, `ad_out` equals the sampled `mem_din`, `mem_oe` is 0 and `mem_dout` is 0. This is the read direction.
- R8: After a rising edge with `den_n` = 0, `dt_r` = 1 and `ale` = 0, `mem_oe` is 1, `mem_dout` equals the sampled `ad_in`, `ad_oe` is 0 and `ad_out` is 0. This is the write direction.
- R9: After a rising edge with `den_n` = 1 or `ale` = 1, both output enables are 0 and both data outputs are 0. In that case `dt_r`, `ad_in` and `mem_din` have no effect.
- R10: `ad_oe` and `mem_oe` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 8 | Shared address/data lines, processor side (input view) |
| a_mid | input | 8 | Address-only lines, bits 15..8 |
| as_hi | input | 4 | Shared address/status lines, bits 19..16 |
| ale | input | 1 | Address-latch strobe, high during the address phase |
| io_m | input | 1 | 1 = I/O access, 0 = memory access |
| rd_n | input | 1 | Active-low read request |
| wr_n | input | 1 | Active-low write request |
| dt_r | input | 1 | Transceiver direction: 0 = toward processor, 1 = toward memory |
| den_n | input | 1 | Active-low transceiver enable |
| mem_din | input | 8 | Data bus, memory side (input view) |
| addr | output | 20 | Held system address |
| memr | output | 1 | Memory read strobe, active high |
| memw | output | 1 | Memory write strobe, active high |
| ior | output | 1 | I/O read strobe, active high |
| iow | output | 1 | I/O write strobe, active high |
| ad_out | output | 8 | Data driven toward the processor side |
| ad_oe | output | 1 | Output enable for `ad_out` |
| mem_dout | output | 8 | Data driven toward the memory side |
| mem_oe | output | 1 | Output enable for `mem_dout` |

## Verification
Address capture can fall in the same cycle as a read or write request and a transceiver enable. The block must load the address while keeping every strobe and both enables low. The bench provokes this with directed cycles that raise `ale` together with a low `rd_n`, `wr_n` and `den_n`, and with random traffic where all these inputs vary on their own each cycle. The opposite overlap also occurs: status values and data bytes move on the shared lines during the data phase while the latch must hold. A bench model judges each case by updating the expected address only on cycles where `ale` was high, and by comparing the strobes and transceiver outputs one edge after each stimulus.

// File: rtl/busdemux_pkg.sv
package busdemux_pkg;

  // Decoded command strobes, all active high.
  typedef struct packed {
    logic memr;
    logic memw;
    logic ior;
    logic iow;
  } strobe_t;

  // Transceiver steering state.
  typedef enum logic [1:0] {
    XDIR_OFF    = 2'b00,
    XDIR_TO_CPU = 2'b01,
    XDIR_TO_MEM = 2'b10
  } xdir_e;

endpackage

// File: rtl/bdm_rst_sync.sv
module bdm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/bdm_addr_latch.sv
module bdm_addr_latch #(
  parameter int LO_W  = 8,
  parameter int MID_W = 8,
  parameter int HI_W  = 4,
  localparam int AW   = LO_W + MID_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ale,
  input  logic [LO_W-1:0]  lo_in,
  input  logic [MID_W-1:0] mid_in,
  input  logic [HI_W-1:0]  hi_in,
  output logic [AW-1:0]    addr
);

  logic [AW-1:0] capture;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;

  // Field placement: low byte at the bottom, status-shared bits at the top.
  assign capture[LO_W-1:0]          = lo_in;
  assign capture[LO_W+MID_W-1:LO_W] = mid_in;
  assign capture[AW-1:LO_W+MID_W]   = hi_in;

  // Next state: load while the strobe is high, otherwise hold.
  always_comb begin
    addr_d = addr_q;
    if (ale) addr_d = capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;

  // R2: a strobed capture shows all fields at once on the next cycle.
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (addr == $past({hi_in, mid_in, lo_in})));

  // R3: without the strobe the held address does not move.
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(addr));

endmodule

// File: rtl/bdm_strobe_dec.sv
module bdm_strobe_dec
  import busdemux_pkg::*;
#(
  parameter bit STROBE_REG = 1'b1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ale,
  input  logic    io_m,
  input  logic    rd_n,
  input  logic    wr_n,
  output strobe_t strb
);

  strobe_t strb_d;
  logic    cmd_ok;

  // Commands are blocked during the address phase.
  assign cmd_ok = !ale;

  always_comb begin
    strb_d.memr = cmd_ok && !rd_n && !io_m;
    strb_d.memw = cmd_ok && !wr_n && !io_m;
    strb_d.ior  = cmd_ok && !rd_n &&  io_m;
    strb_d.iow  = cmd_ok && !wr_n &&  io_m;
  end

  generate
    if (STROBE_REG) begin : g_reg
      strobe_t strb_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strb_q <= '0;
        else        strb_q <= strb_d;
      end

      assign strb = strb_q;

      // R4: a memory strobe needs a memory access requested outside the address phase.
      p_mem_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.memr || strb.memw) |-> $past(!io_m && !ale));

      // R5: an I/O strobe needs an I/O access.
      p_io_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.ior || strb.iow) |-> $past(io_m));

      // R6: address phase silences every command on the following cycle.
      p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (strb == '0));

      // R4: a read request on memory space yields the read strobe.
      p_memr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && !rd_n && !io_m) |=> strb.memr);
    end else begin : g_comb
      assign strb = strb_d;
    end
  endgenerate

endmodule

// File: rtl/bdm_xcvr.sv
module bdm_xcvr
  import busdemux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              den_n,
  input  logic              dt_r,
  input  logic [DATA_W-1:0] cpu_in,
  input  logic [DATA_W-1:0] mem_in,
  output logic [DATA_W-1:0] cpu_out,
  output logic              cpu_oe,
  output logic [DATA_W-1:0] mem_out,
  output logic              mem_oe
);

  xdir_e             dir_d, dir_q;
  logic [DATA_W-1:0] cpu_d, cpu_q;
  logic [DATA_W-1:0] mem_d, mem_q;

  // Next state: direction, then data picked for that direction only.
  always_comb begin
    dir_d = XDIR_OFF;
    if (!den_n && !ale) dir_d = dt_r ? XDIR_TO_MEM : XDIR_TO_CPU;
    cpu_d = (dir_d == XDIR_TO_CPU) ? mem_in : '0;
    mem_d = (dir_d == XDIR_TO_MEM) ? cpu_in : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= XDIR_OFF;
      cpu_q <= '0;
      mem_q <= '0;
    end else begin
      dir_q <= dir_d;
      cpu_q <= cpu_d;
      mem_q <= mem_d;
    end
  end

  assign cpu_oe  = (dir_q == XDIR_TO_CPU);
  assign mem_oe  = (dir_q == XDIR_TO_MEM);
  assign cpu_out = cpu_q;
  assign mem_out = mem_q;

  // R7: driving toward the processor carries the memory-side byte.
  p_cpu_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_oe |-> (cpu_out == $past(mem_in)) && $past(!dt_r && !den_n));

  // R8: driving toward memory carries the processor-side byte.
  p_mem_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe |-> (mem_out == $past(cpu_in)) && $past(dt_r && !den_n));

  // R9: disabled or address phase leaves both sides undriven.
  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (den_n || ale) |=> (!cpu_oe && !mem_oe && cpu_out == '0 && mem_out == '0));

  // R10: never both directions at once.
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_oe && mem_oe));

endmodule

// File: rtl/bus_demux_ctrl.sv
module bus_demux_ctrl
  import busdemux_pkg::*;
#(
  parameter int LO_W       = 8,
  parameter int MID_W      = 8,
  parameter int HI_W       = 4,
  parameter bit STROBE_REG = 1'b1,
  localparam int AW        = LO_W + MID_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LO_W-1:0]  ad_in,
  input  logic [MID_W-1:0] a_mid,
  input  logic [HI_W-1:0]  as_hi,
  input  logic             ale,
  input  logic             io_m,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             dt_r,
  input  logic             den_n,
  input  logic [LO_W-1:0]  mem_din,
  output logic [AW-1:0]    addr,
  output logic             memr,
  output logic             memw,
  output logic             ior,
  output logic             iow,
  output logic [LO_W-1:0]  ad_out,
  output logic             ad_oe,
  output logic [LO_W-1:0]  mem_dout,
  output logic             mem_oe
);

  logic    rst_q_n;
  strobe_t strb;

  bdm_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  bdm_addr_latch #(.LO_W(LO_W), .MID_W(MID_W), .HI_W(HI_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .ale    (ale),
    .lo_in  (ad_in),
    .mid_in (a_mid),
    .hi_in  (as_hi),
    .addr   (addr)
  );

  bdm_strobe_dec #(.STROBE_REG(STROBE_REG)) u_dec (
    .clk   (clk),
    .rst_n (rst_q_n),
    .ale   (ale),
    .io_m  (io_m),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .strb  (strb)
  );

  assign memr = strb.memr;
  assign memw = strb.memw;
  assign ior  = strb.ior;
  assign iow  = strb.iow;

  bdm_xcvr #(.DATA_W(LO_W)) u_xcvr (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .ale     (ale),
    .den_n   (den_n),
    .dt_r    (dt_r),
    .cpu_in  (ad_in),
    .mem_in  (mem_din),
    .cpu_out (ad_out),
    .cpu_oe  (ad_oe),
    .mem_out (mem_dout),
    .mem_oe  (mem_oe)
  );

  // R1: reset clears the held address and every command.
  p_reset_r1: assert property (@(posedge clk)
    !rst_q_n |=> (addr == '0 && !memr && !memw && !ior && !iow));

endmodule

// File: tb/tb_bus_demux_ctrl.sv
module tb_bus_demux_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ad_in, a_mid, mem_din;
  logic [3:0]  as_hi;
  logic        ale, io_m, rd_n, wr_n, dt_r, den_n;
  logic [19:0] addr;
  logic        memr, memw, ior, iow, ad_oe, mem_oe;
  logic [7:0]  ad_out, mem_dout;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Expected values after the next edge.
  logic [19:0] e_addr;
  logic        e_memr, e_memw, e_ior, e_iow, e_ad_oe, e_mem_oe;
  logic [7:0]  e_ad_out, e_mem_dout;
  bit          e_ale, e_en, have_exp;

  always #2 clk = ~clk;

  bus_demux_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .a_mid(a_mid), .as_hi(as_hi),
    .ale(ale), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n), .dt_r(dt_r),
    .den_n(den_n), .mem_din(mem_din), .addr(addr), .memr(memr), .memw(memw),
    .ior(ior), .iow(iow), .ad_out(ad_out), .ad_oe(ad_oe),
    .mem_dout(mem_dout), .mem_oe(mem_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] next_addr(input logic [19:0] cur, input logic a,
      input logic [3:0] hi, input logic [7:0] mid, input logic [7:0] lo);
    return a ? {hi, mid, lo} : cur;
  endfunction

  task automatic compare();
    chk(addr == e_addr, e_ale ? "R2 addr capture" : "R3 addr hold", addr, e_addr);
    if (e_ale)
      chk({memr, memw, ior, iow} == 4'b0, "R6 strobes quiet", {memr, memw, ior, iow}, 0);
    chk({memr, memw} == {e_memr, e_memw}, "R4 mem strobes", {memr, memw}, {e_memr, e_memw});
    chk({ior, iow} == {e_ior, e_iow}, "R5 io strobes", {ior, iow}, {e_ior, e_iow});
    if (!e_en)
      chk({ad_oe, mem_oe, ad_out, mem_dout} == 18'd0, "R9 xcvr off",
          {ad_oe, mem_oe, ad_out, mem_dout}, 0);
    else if (e_ad_oe)
      chk({ad_oe, mem_oe, ad_out, mem_dout} == {2'b10, e_ad_out, 8'h00}, "R7 read path",
          {ad_oe, mem_oe, ad_out, mem_dout}, {2'b10, e_ad_out, 8'h00});
    else
      chk({ad_oe, mem_oe, ad_out, mem_dout} == {2'b01, 8'h00, e_mem_dout}, "R8 write path",
          {ad_oe, mem_oe, ad_out, mem_dout}, {2'b01, 8'h00, e_mem_dout});
    chk(!(ad_oe && mem_oe), "R10 exclusive enables", {ad_oe, mem_oe}, 0);
  endtask

  // One clock: check the previous stimulus, then apply the next one.
  task automatic drive(input logic a, input logic iom, input logic rd, input logic wr,
      input logic dir, input logic den, input logic [7:0] lo, input logic [7:0] mid,
      input logic [3:0] hi, input logic [7:0] md);
    @(negedge clk);
    if (have_exp) compare();
    ale = a; io_m = iom; rd_n = rd; wr_n = wr; dt_r = dir; den_n = den;
    ad_in = lo; a_mid = mid; as_hi = hi; mem_din = md;
    e_ale      = a;
    e_addr     = next_addr(e_addr, a, hi, mid, lo);
    e_memr     = !a && !rd && !iom;
    e_memw     = !a && !wr && !iom;
    e_ior      = !a && !rd && iom;
    e_iow      = !a && !wr && iom;
    e_en       = !den && !a;
    e_ad_oe    = e_en && !dir;
    e_mem_oe   = e_en && dir;
    e_ad_out   = e_ad_oe ? md : 8'h00;
    e_mem_dout = e_mem_oe ? lo : 8'h00;
    have_exp   = 1'b1;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 4'h0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    have_exp = 1'b0;
    e_addr = '0;
    rst_n = 1'b0;
    ale = 1'b1; io_m = 1'b0; rd_n = 1'b0; wr_n = 1'b0; dt_r = 1'b0; den_n = 1'b0;
    ad_in = 8'h5A; a_mid = 8'hA5; as_hi = 4'hF; mem_din = 8'h33;
    repeat (4) @(negedge clk);
    // R1: outputs cleared while reset is held, despite active inputs.
    chk(addr == 20'h0, "R1 reset addr", addr, 0);
    chk({memr, memw, ior, iow, ad_oe, mem_oe} == 6'b0, "R1 reset strobes/enables",
        {memr, memw, ior, iow, ad_oe, mem_oe}, 0);
    chk({ad_out, mem_dout} == 16'h0, "R1 reset data", {ad_out, mem_dout}, 0);
    ale = 1'b0; rd_n = 1'b1; wr_n = 1'b1; den_n = 1'b1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(addr == 20'h0, "R1 after release addr", addr, 0);

    // Memory read cycle at A0023, status on the top lines during data phase.
    drive(1, 0, 1, 1, 0, 1, 8'h23, 8'h00, 4'hA, 8'h00);  // T1
    drive(0, 0, 0, 1, 0, 0, 8'hFF, 8'h00, 4'h5, 8'h7D);  // T2
    drive(0, 0, 0, 1, 0, 0, 8'hFF, 8'h00, 4'h6, 8'h7E);  // T3
    drive(0, 0, 1, 1, 0, 1, 8'h00, 8'h00, 4'h6, 8'h00);  // T4
    // I/O write cycle at 00080.
    drive(1, 1, 1, 1, 1, 1, 8'h80, 8'h00, 4'h0, 8'h00);
    drive(0, 1, 1, 0, 1, 0, 8'hC3, 8'h00, 4'h3, 8'h11);
    drive(0, 1, 1, 0, 1, 0, 8'hC3, 8'h00, 4'h3, 8'h11);
    drive(0, 1, 1, 1, 1, 1, 8'h00, 8'h00, 4'h3, 8'h00);
    // Corner: address phase overlapping read, write and enable requests (R6, R9).
    drive(1, 0, 0, 0, 0, 0, 8'hFF, 8'hFF, 4'hF, 8'h99);
    drive(1, 1, 0, 0, 1, 0, 8'h01, 8'h80, 4'h8, 8'h42);
    // Corner: enable off, direction toggling, data ignored (R9).
    drive(0, 0, 1, 1, 1, 1, 8'hAA, 8'h55, 4'h1, 8'hBB);
    drive(0, 0, 1, 1, 0, 1, 8'hAA, 8'h55, 4'h1, 8'hBB);
    // Memory write cycle at 7FFFF.
    drive(1, 0, 1, 1, 1, 1, 8'hFF, 8'hFF, 4'h7, 8'h00);
    drive(0, 0, 1, 0, 1, 0, 8'h36, 8'h12, 4'h0, 8'h00);
    idle();

    void'($urandom(32'd20240601));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom();
      drive(r[1:0] == 2'b00, r[2], r[3], r[4], r[5], r[6],
            r[15:8], r[23:16], r[27:24], r[31:24] ^ r[7:0]);
    end
    idle();
    idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule